// File: doc/BRIEF.md
# Memory-Mapped UART Register Bank

This block is the register side of a simple UART. It sits on an APB-style peripheral bus. It gathers received characters into a byte-wide FIFO, drives outgoing characters onto a byte stream, and raises a single interrupt line. The serial shifter, baud timing, parity and flow control live elsewhere. Characters arrive on a valid/ready stream and leave on a valid-only stream. The bit-level transmitter is assumed to be always idle.

Software reads the data word to take the oldest received character. It writes the data word to send a character. A control word holds the enables and is stored in full, so unused bits still read back. A status word reports FIFO occupancy. The scaler word and the rest of the 20-byte window read as zero.

Top module: `uart_regbank`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x00000006, the receive FIFO is empty, and neither `irq` nor `tx_valid` is high.
- R2: Only the low 8 address bits are decoded. Offset 0x00 and offset 0x03 both select the data word for reads and writes, 0x04 selects status, 0x08 selects control and 0x0C selects scaler.
- R3: A write to control (0x08) stores all 32 bits, and a later read returns them unchanged. Writes to status (0x04) change nothing.
- R4: Reads of scaler (0x0C), of 0x10 and of any other unmapped offset return 0, and writes to those offsets have no effect.
- R5: A character handed over on the receive stream is stored only while control bit 0 (receive enable) is 1. With that bit at 0 the handshake still completes and the character is dropped.
- R6: The status word has these bits: bit 0 is 1 when the FIFO holds data, bits 1 and 2 are always 1, bit 8 is 1 when the FIFO holds at least half its depth, and bit 10 is 1 when the FIFO is full. All other bits read 0.
- R7: A read of the data word returns the oldest stored character in the low 8 bits and removes it, in arrival order. A read of an empty FIFO returns 0.
- R8: A character is removed once per completed read access (PSEL and PENABLE both high) to the data word, and only then. Setup phases, writes and reads of other offsets leave the FIFO unchanged.
- R9: `rx_ready` is low exactly while the FIFO is full. A character held waiting on a full FIFO is accepted once a read frees a slot, and no character is lost.
- R10: A write to the data word while control bit 1 (transmit enable) is 1 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to the low 8 bits written. With that bit at 0 the write produces no output.
- R11: `irq` pulses high for one cycle, in the cycle after the event, when a character is stored while control bit 2 is 1, or when a character is sent while control bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; only the low 8 bits are decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Received character present |
| rx_ready | output | 1 | FIFO can take a character |
| tx_data | output | 8 | Character to send |
| tx_valid | output | 1 | One-cycle send strobe |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is a full FIFO with a character already waiting on the receive stream at the moment software reads. In that cycle the pop frees a slot and the waiting character must enter behind the others, with nothing lost.

The stimulus reaches it in three steps. It first fills the FIFO to its depth. It then holds `rx_valid` high with a marker byte while it checks that `rx_ready` is low. Finally it issues a data read in parallel with that stalled handshake. Draining the FIFO afterwards must return every stored byte in order, ending with the marker. The status word is read after each drain step, so the half and full thresholds are checked on the way down.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CHAR_W = 8;

    // Decoded offsets (low 8 address bits)
    localparam logic [7:0] OFS_DATA      = 8'h00;
    localparam logic [7:0] OFS_DATA_BYTE = 8'h03;
    localparam logic [7:0] OFS_STAT      = 8'h04;
    localparam logic [7:0] OFS_CTRL      = 8'h08;
    localparam logic [7:0] OFS_SCAL      = 8'h0C;

    // Control bits that this block acts upon
    localparam int unsigned CB_RX_EN  = 0;
    localparam int unsigned CB_TX_EN  = 1;
    localparam int unsigned CB_RX_IRQ = 2;
    localparam int unsigned CB_TX_IRQ = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL,
        SEL_SCAL
    } reg_sel_e;

    typedef struct packed {
        logic [20:0] rsvd;
        logic        rx_full;
        logic        tx_full;
        logic        rx_half;
        logic        tx_half;
        logic        frame_err;
        logic        par_err;
        logic        overrun;
        logic        brk;
        logic        tx_q_empty;
        logic        tx_sh_empty;
        logic        rx_avail;
    } stat_word_t;

    function automatic stat_word_t make_status(input logic avail,
                                               input logic half,
                                               input logic full);
        stat_word_t s;
        s             = '0;
        s.rx_avail    = avail;
        s.tx_sh_empty = 1'b1;
        s.tx_q_empty  = 1'b1;
        s.rx_half     = half;
        s.rx_full     = full;
        return s;
    endfunction

endpackage

// File: rtl/urb_decode.sv
module urb_decode
    import uart_regbank_pkg::*;
(
    input  logic [7:0] ofs,
    output reg_sel_e   sel
);
    always_comb begin
        unique case (ofs)
            OFS_DATA, OFS_DATA_BYTE: sel = SEL_DATA;
            OFS_STAT:                sel = SEL_STAT;
            OFS_CTRL:                sel = SEL_CTRL;
            OFS_SCAL:                sel = SEL_SCAL;
            default:                 sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/urb_rx_fifo.sv
module urb_rx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         half,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= step(wr_ptr);
            end
            if (pop) rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));
    assign half  = (count_q >= CNT_W'(DEPTH / 2));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              irq
);
    logic              unused_addr_hi;
    reg_sel_e          sel;
    logic              access, rd_acc, wr_acc;
    logic              push, pop, send;
    logic              q_empty, q_half, q_full;
    logic [CHAR_W-1:0] q_head;
    logic [WORD_W-1:0] ctrl_q;
    stat_word_t        stat;

    assign unused_addr_hi = ^paddr[ADDR_W-1:8];

    urb_decode u_dec (
        .ofs (paddr[7:0]),
        .sel (sel)
    );

    assign access = psel & penable;
    assign rd_acc = access & ~pwrite;
    assign wr_acc = access & pwrite;

    assign rx_ready = ~q_full;
    assign push     = rx_valid & ~q_full & ctrl_q[CB_RX_EN];
    assign pop      = rd_acc & (sel == SEL_DATA) & ~q_empty;
    assign send     = wr_acc & (sel == SEL_DATA) & ctrl_q[CB_TX_EN];

    urb_rx_fifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (rx_data),
        .pop   (pop),
        .dout  (q_head),
        .empty (q_empty),
        .half  (q_half),
        .full  (q_full)
    );

    assign stat = make_status(~q_empty, q_half, q_full);

    always_comb begin
        unique case (sel)
            SEL_DATA: prdata = q_empty ? '0 : {{(WORD_W-CHAR_W){1'b0}}, q_head};
            SEL_STAT: prdata = stat;
            SEL_CTRL: prdata = ctrl_q;
            default:  prdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            irq      <= 1'b0;
        end else begin
            if (wr_acc && sel == SEL_CTRL) ctrl_q <= pwdata;
            tx_valid <= send;
            if (send) tx_data <= pwdata[CHAR_W-1:0];
            irq <= (push & ctrl_q[CB_RX_IRQ]) | (send & ctrl_q[CB_TX_IRQ]);
        end
    end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [7:0]  ofs,
    input logic [31:0] prdata,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        rx_en,
    input logic        tx_valid,
    input logic        irq
);
    int unsigned shadow;
    logic        data_rd, stat_rd, take;

    assign data_rd = psel && penable && !pwrite && (ofs == 8'h00 || ofs == 8'h03);
    assign stat_rd = psel && penable && !pwrite && ofs == 8'h04;
    assign take    = rx_valid && rx_ready && rx_en;

    always_ff @(posedge clk) begin
        if (rst) shadow <= 0;
        else     shadow <= shadow + (take ? 1 : 0) - ((data_rd && shadow != 0) ? 1 : 0);
    end

    // R1: outputs quiet after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!irq && !tx_valid));

    // R6: idle-transmitter bits always set in a status read
    assert_tx_idle_bits_R6: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> prdata[2:1] == 2'b11);

    // R7: reading an empty FIFO yields zero
    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (data_rd && shadow == 0) |-> prdata == 32'd0);

    // R9: ready mirrors the occupancy counted from the ports
    assert_ready_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        rx_ready == (shadow != DEPTH));

    // R10: a send strobe follows a completed write
    assert_tx_after_write_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(psel && penable && pwrite));

    // R11: an interrupt follows a write or a character handover
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past((psel && penable && pwrite) || (rx_valid && rx_ready)));
endmodule

bind uart_regbank uart_regbank_chk #(.DEPTH(RX_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .ofs      (paddr[7:0]),
    .prdata   (prdata),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_en    (ctrl_q[0]),
    .tx_valid (tx_valid),
    .irq      (irq)
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          irq;

    int vectors = 0, miscompares = 0;
    int irq_seen = 0, irq_exp = 0;
    logic irq_prev = 1'b0;
    bit done = 0;
    logic [31:0] ctrl_mdl = '0;
    logic [7:0]  mdl[$];
    logic [31:0] rd_exp[$];
    string       rd_tag[$];
    logic [7:0]  tx_exp[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank #(.ADDR_W(AW), .RX_DEPTH(DEPTH)) i_uart_regbank (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_exp();
        logic [31:0] s = 32'h6;
        if (mdl.size() > 0)          s[0]  = 1'b1;
        if (mdl.size() >= DEPTH / 2) s[8]  = 1'b1;
        if (mdl.size() == DEPTH)     s[10] = 1'b1;
        return s;
    endfunction

    // Monitor: compare read data and send strobes against the scoreboard
    always @(negedge clk) begin
        if (!rst && psel && penable && !pwrite) begin
            if (rd_exp.size() == 0) check("R2 unexpected read", prdata, 32'hx);
            else check(rd_tag.pop_front(), prdata, rd_exp.pop_front());
        end
        if (!rst && tx_valid) begin
            if (tx_exp.size() == 0) check("R10 unexpected send", {24'd0, tx_data}, 32'hDEAD);
            else check("R10 tx_data", {24'd0, tx_data}, {24'd0, tx_exp.pop_front()});
        end
        if (!rst && irq) begin
            irq_seen++;
            if (irq_prev) check("R11 irq wider than one cycle", 32'd1, 32'd0);
        end
        irq_prev = irq;
    end

    task automatic bus(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        rd_exp.push_back(exp);
        rd_tag.push_back(tag);
        bus(1'b0, a, 32'd0);
    endtask

    task automatic rd_data(input logic [AW-1:0] a, input string tag);
        logic [31:0] e = 32'd0;
        if (mdl.size() > 0) e = {24'd0, mdl.pop_front()};
        rd(a, e, tag);
    endtask

    task automatic rd_stat(input string tag);
        rd(12'h004, stat_exp(), tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        if ((a[7:0] == 8'h00 || a[7:0] == 8'h03) && ctrl_mdl[1]) begin
            tx_exp.push_back(d[7:0]);
            if (ctrl_mdl[3]) irq_exp++;
        end
        bus(1'b1, a, d);
        if (a[7:0] == 8'h08) ctrl_mdl = d;
    endtask

    task automatic push_byte(input logic [7:0] b);
        logic r;
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        forever begin
            @(negedge clk); r = rx_ready;
            @(posedge clk);
            if (r) break;
        end
        if (ctrl_mdl[0]) begin
            mdl.push_back(b);
            if (ctrl_mdl[2]) irq_exp++;
        end
        #1 rx_valid = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        repeat (2) @(posedge clk);
        #1 check(tag, irq_seen, irq_exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 irq after reset", irq, 1'b0);
        check("R1 tx_valid after reset", tx_valid, 1'b0);
        rd(12'h004, 32'h6, "R1 status after reset");
        rd(12'h008, 32'h0, "R1 control after reset");
        rd_data(12'h000, "R1 data after reset empty");

        // R3 control storage, status write ignored
        wr(12'h008, 32'h8000_1FF0);
        rd(12'h008, 32'h8000_1FF0, "R3 control readback");
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, 32'h6, "R3 status write ignored");

        // R4 scaler and unmapped
        wr(12'h00C, 32'h1234_5678);
        rd(12'h00C, 32'h0, "R4 scaler reads zero");
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, 32'h0, "R4 offset 0x10 reads zero");
        rd(12'h014, 32'h0, "R4 offset 0x14 reads zero");
        rd(12'h0FC, 32'h0, "R4 offset 0xFC reads zero");
        rd(12'h008, 32'h8000_1FF0, "R4 control untouched by unmapped writes");

        // R5 receive disabled drops characters
        wr(12'h008, 32'h0);
        push_byte(8'h5A);
        rd_stat("R5 status after dropped char");
        rd_data(12'h000, "R5 dropped char not readable");
        chk_irq("R11 no irq when disabled");

        // R5/R7/R2/R11 basic receive with interrupt
        wr(12'h008, 32'h5);
        push_byte(8'h11);
        push_byte(8'h22);
        push_byte(8'h33);
        chk_irq("R11 one irq per stored char");
        rd_stat("R6 status with data");
        rd_data(12'h000, "R7 oldest first at 0x00");
        rd_data(12'h003, "R2 data alias at 0x03");
        rd_stat("R8 status read does not pop");
        rd_data(12'h100, "R2 upper address bits ignored");
        rd_stat("R6 status empty again");
        rd_data(12'h000, "R7 empty read returns zero");

        // R8 setup-only and write to data do not pop
        wr(12'h008, 32'h1);
        push_byte(8'h44);
        wr(12'h000, 32'h99);
        rd_data(12'h003, "R8 write does not pop");

        // R9 fill, stall, pop-while-stalled
        for (int i = 0; i < DEPTH; i++) push_byte(8'hA0 + 8'(i));
        rd_stat("R6 status full");
        @(negedge clk);
        check("R9 ready low when full", rx_ready, 1'b0);
        fork
            push_byte(8'hEE);
            rd_data(12'h000, "R9 pop while char waiting");
        join
        rd_stat("R9 full again after waiting char enters");
        while (mdl.size() > 0) begin
            rd_data(12'h000, "R9 drain order");
            rd_stat("R6 status while draining");
        end
        check("R9 ready high when empty", rx_ready, 1'b1);

        // R10/R11 transmit
        wr(12'h008, 32'h0);
        wr(12'h000, 32'h41);
        wr(12'h008, 32'h2);
        wr(12'h000, 32'h1C3);
        chk_irq("R11 no irq without tx irq enable");
        wr(12'h008, 32'hA);
        wr(12'h003, 32'h5E);
        wr(12'h004, 32'h77);
        chk_irq("R11 irq on send");
        repeat (3) @(posedge clk);
        check("R10 all expected sends seen", tx_exp.size(), 0);
        check("R2 all expected reads seen", rd_exp.size(), 0);
        finish_run();
    end
endmodule